// File: doc/BRIEF.md
# Telephony Event Interrupt Controller

This block merges line events from a telephone front end into a single active-low interrupt request for a host microcontroller. It takes four kinds of event. The first is a change on either of two line-polarity comparator outputs. The second is a detect pulse from a dual-tone alert detector, qualified by a level-ok signal. The third is a byte-received pulse from an FSK framer. The fourth is a timebase that counts a slow 32.768 kHz clock and ticks once per second or once per minute. Each event that is enabled sets a sticky flag. The host reads the flags through a small parallel register port and clears them by writing ones.

The block runs in two clock domains. The polarity path, the timebase and their flags run on the slow clock, so that a polarity reversal or a timebase tick can pull the interrupt low while the fast system clock is stopped for power-down. The register port, the tone and FSK flags and the tone warm-up window run on the fast clock. Mode bits and clear requests cross from the fast domain into the slow domain through two-flop synchronisers. Each slow-flag clear uses a toggle request and a toggle acknowledge.

Top module: `tel_irq_ctrl`

## Requirements
- R1: After reset the mode register (address 0) reads 0x00, the interrupt register (address 2) reads 0x00, and irq_n is high.
- R2: While mode bit 4 (polarity enable) is set, a change of level on pol_a or pol_b sets interrupt bit 6. While mode bit 4 is clear, such changes leave bit 6 at 0.
- R3: Status register (address 1) bit 7 shows the synchronised level of pol_a and bit 6 shows the synchronised level of pol_b. Its other bits read 0.
- R4: With mode bit 0 (timebase enable) set and mode bit 1 clear, interrupt bit 7 is set once every TICKS_PER_SEC slow-clock cycles.
- R5: With mode bits 0 and 1 both set, bit 7 is set once every TICKS_PER_SEC*SECS_PER_MIN slow-clock cycles. A change of mode bit 1 restarts the count from zero, so the first tick after the change comes one full period after the change takes effect.
- R6: A polarity event and a timebase tick each drive irq_n low while the fast clock is stopped.
- R7: With mode bit 2 (tone enable) set, a tone_det pulse sets interrupt bit 1. A pulse in any of the first INIT_CYCLES fast cycles after the enable bit is registered is ignored. Tone pulses are ignored while mode bit 2 is clear.
- R8: A tone_det pulse is ignored while tone_lvl_ok is low.
- R9: With mode bit 3 (FSK enable) set, an fsk_byte pulse sets interrupt bit 5. While mode bit 3 is clear, the pulse is ignored.
- R10: Writing the interrupt register clears each flag whose data bit is 1 and leaves the other flags unchanged. irq_n stays low while any flag is set and goes high once all flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast system clock; may be stopped in power-down |
| clk_slow | input | 1 | 32.768 kHz low-power clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pol_a | input | 1 | Polarity comparator output A (asynchronous) |
| pol_b | input | 1 | Polarity comparator output B (asynchronous) |
| tone_det | input | 1 | Dual-tone detect pulse, fast domain |
| tone_lvl_ok | input | 1 | Tone input level above threshold |
| fsk_byte | input | 1 | FSK byte-received pulse, fast domain |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest behaviour to reach from the ports is the edge of the tone warm-up window. A detect pulse on the last cycle of the window must be dropped, and a pulse on the very next cycle must be taken. The bench drives both pulses at exact cycle offsets from the mode write. A second hard case is a change of the timebase period in the middle of a count. The bench writes the new period just after a seconds tick and then measures the slow-clock distance to the next tick. That distance separates a restarted count from a continued one. The power-down behaviour is reached by gating the fast clock off in the bench before driving the polarity inputs or waiting for a tick.

// File: rtl/tel_irq_pkg.sv
package tel_irq_pkg;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_INT  = 2'd2
    } reg_sel_e;

    // mode register bits
    localparam int MB_TB_EN   = 0;
    localparam int MB_TB_MIN  = 1;
    localparam int MB_TONE_EN = 2;
    localparam int MB_FSK_EN  = 3;
    localparam int MB_POL_EN  = 4;
    localparam int MODE_W     = 5;

    // interrupt register bits
    localparam int IB_TONE = 1;
    localparam int IB_FSK  = 5;
    localparam int IB_POL  = 6;
    localparam int IB_TB   = 7;

    // status register bits
    localparam int SB_POL_A = 7;
    localparam int SB_POL_B = 6;

    // slow-domain flag indices
    localparam int SF_POL = 0;
    localparam int SF_TB  = 1;
    localparam int SF_N   = 2;

    typedef struct packed {
        logic [1:0]      pol_prev;
        logic [SF_N-1:0] flag;
        logic [SF_N-1:0] ack;
    } slow_st_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [SF_N-1:0]   clr_tgl;
    } fast_st_t;

endpackage

// File: rtl/tel_sync2.sv
module tel_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/tel_timebase.sv
module tel_timebase #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SECS_PER_MIN  = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic minute_sel,
    output logic tick
);
    localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam int SW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;

    typedef struct packed {
        logic [PW-1:0] presc;
        logic [SW-1:0] sec;
        logic          sel_prev;
    } tb_st_t;

    tb_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        tick          = 1'b0;
        st_d.sel_prev = minute_sel;
        if (!en) begin
            st_d.presc = '0;
            st_d.sec   = '0;
        end else if (minute_sel != st_q.sel_prev) begin
            st_d.presc = '0;
            st_d.sec   = '0;
        end else if (st_q.presc == PW'(TICKS_PER_SEC - 1)) begin
            st_d.presc = '0;
            if (minute_sel) begin
                if (st_q.sec == SW'(SECS_PER_MIN - 1)) begin
                    st_d.sec = '0;
                    tick     = 1'b1;
                end else begin
                    st_d.sec = st_q.sec + 1'b1;
                end
            end else begin
                tick = 1'b1;
            end
        end else begin
            st_d.presc = st_q.presc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
endmodule

// File: rtl/tel_slow_events.sv
module tel_slow_events
    import tel_irq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SECS_PER_MIN  = 60
) (
    input  logic            clk_slow,
    input  logic            rst_n,
    input  logic [1:0]      pol_raw,
    input  logic            pol_en,
    input  logic            tb_en,
    input  logic            tb_min,
    input  logic [SF_N-1:0] clr_req,
    output logic [1:0]      pol_lvl,
    output logic [SF_N-1:0] flag,
    output logic [SF_N-1:0] clr_ack
);
    logic [1:0]      pol_s;
    logic [2:0]      mode_s;
    logic [SF_N-1:0] req_s;
    logic            tb_tick;
    logic            pol_edge;
    logic [SF_N-1:0] set_v;
    logic [SF_N-1:0] clr_hit;

    slow_st_t st_d, st_q;

    tel_sync2 #(.W(2)) u_pol_sync (
        .clk(clk_slow), .rst_n(rst_n), .d(pol_raw), .q(pol_s));

    tel_sync2 #(.W(3)) u_mode_sync (
        .clk(clk_slow), .rst_n(rst_n), .d({pol_en, tb_min, tb_en}), .q(mode_s));

    tel_sync2 #(.W(SF_N)) u_req_sync (
        .clk(clk_slow), .rst_n(rst_n), .d(clr_req), .q(req_s));

    tel_timebase #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .SECS_PER_MIN (SECS_PER_MIN)
    ) u_tb (
        .clk       (clk_slow),
        .rst_n     (rst_n),
        .en        (mode_s[0]),
        .minute_sel(mode_s[1]),
        .tick      (tb_tick)
    );

    always_comb begin
        st_d          = st_q;
        pol_edge      = |(pol_s ^ st_q.pol_prev);
        set_v         = '0;
        set_v[SF_POL] = pol_edge & mode_s[2];
        set_v[SF_TB]  = tb_tick;
        clr_hit       = req_s ^ st_q.ack;
        st_d.pol_prev = pol_s;
        st_d.ack      = req_s;
        st_d.flag     = set_v | (st_q.flag & ~clr_hit);
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pol_lvl = pol_s;
    assign flag    = st_q.flag;
    assign clr_ack = st_q.ack;

    AST_POL_GATED: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $rose(st_q.flag[SF_POL]) |-> $past(mode_s[2])); // R2
    AST_TB_GATED: assert property (@(posedge clk_slow) disable iff (!rst_n)
        $rose(st_q.flag[SF_TB]) |-> $past(mode_s[0])); // R4
endmodule

// File: rtl/tel_tone_gate.sv
module tel_tone_gate #(
    parameter int INIT_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_en,
    input  logic fsk_en,
    input  logic tone_pulse,
    input  logic level_ok,
    input  logic fsk_pulse,
    input  logic clr_tone,
    input  logic clr_fsk,
    output logic tone_flag,
    output logic fsk_flag
);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tone;
        logic          fsk;
    } tg_st_t;

    tg_st_t st_d, st_q;
    logic   tone_set;
    logic   fsk_set;

    always_comb begin
        st_d     = st_q;
        tone_set = tone_en & level_ok & tone_pulse & (st_q.cnt == '0);
        fsk_set  = fsk_en & fsk_pulse;
        if (!tone_en)
            st_d.cnt = CW'(INIT_CYCLES);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
        st_d.tone = tone_set | (st_q.tone & ~clr_tone);
        st_d.fsk  = fsk_set  | (st_q.fsk  & ~clr_fsk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cnt  <= CW'(INIT_CYCLES);
        end else begin
            st_q <= st_d;
        end
    end

    assign tone_flag = st_q.tone;
    assign fsk_flag  = st_q.fsk;

    AST_TONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tone) |-> $past(st_q.cnt == '0 && tone_en)); // R7
    AST_TONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tone) |-> $past(level_ok && tone_pulse)); // R8
    AST_FSK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fsk) |-> $past(fsk_en && fsk_pulse)); // R9
endmodule

// File: rtl/tel_irq_ctrl.sv
module tel_irq_ctrl
    import tel_irq_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int SECS_PER_MIN  = 60,
    parameter int INIT_CYCLES   = 100
) (
    input  logic       clk_fast,
    input  logic       clk_slow,
    input  logic       rst_n,
    input  logic       pol_a,
    input  logic       pol_b,
    input  logic       tone_det,
    input  logic       tone_lvl_ok,
    input  logic       fsk_byte,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_n
);
    fast_st_t        st_d, st_q;
    logic [SF_N-1:0] slow_flag;
    logic [SF_N-1:0] slow_ack;
    logic [SF_N-1:0] ack_s;
    logic [SF_N-1:0] flag_s;
    logic [1:0]      pol_lvl;
    logic [1:0]      pol_lvl_s;
    logic            tone_flag;
    logic            fsk_flag;
    logic            wr_mode;
    logic            wr_int;

    assign wr_mode = reg_wr && (reg_addr == SEL_MODE);
    assign wr_int  = reg_wr && (reg_addr == SEL_INT);

    tel_slow_events #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .SECS_PER_MIN (SECS_PER_MIN)
    ) u_slow (
        .clk_slow(clk_slow),
        .rst_n   (rst_n),
        .pol_raw ({pol_b, pol_a}),
        .pol_en  (st_q.mode[MB_POL_EN]),
        .tb_en   (st_q.mode[MB_TB_EN]),
        .tb_min  (st_q.mode[MB_TB_MIN]),
        .clr_req (st_q.clr_tgl),
        .pol_lvl (pol_lvl),
        .flag    (slow_flag),
        .clr_ack (slow_ack)
    );

    tel_sync2 #(.W(SF_N)) u_ack_sync (
        .clk(clk_fast), .rst_n(rst_n), .d(slow_ack), .q(ack_s));

    tel_sync2 #(.W(SF_N)) u_flag_sync (
        .clk(clk_fast), .rst_n(rst_n), .d(slow_flag), .q(flag_s));

    tel_sync2 #(.W(2)) u_lvl_sync (
        .clk(clk_fast), .rst_n(rst_n), .d(pol_lvl), .q(pol_lvl_s));

    tel_tone_gate #(.INIT_CYCLES(INIT_CYCLES)) u_tone (
        .clk       (clk_fast),
        .rst_n     (rst_n),
        .tone_en   (st_q.mode[MB_TONE_EN]),
        .fsk_en    (st_q.mode[MB_FSK_EN]),
        .tone_pulse(tone_det),
        .level_ok  (tone_lvl_ok),
        .fsk_pulse (fsk_byte),
        .clr_tone  (wr_int && reg_wdata[IB_TONE]),
        .clr_fsk   (wr_int && reg_wdata[IB_FSK]),
        .tone_flag (tone_flag),
        .fsk_flag  (fsk_flag)
    );

    always_comb begin
        st_d = st_q;
        if (wr_mode)
            st_d.mode = reg_wdata[MODE_W-1:0];
        if (wr_int) begin
            if (reg_wdata[IB_POL] && (st_q.clr_tgl[SF_POL] == ack_s[SF_POL]))
                st_d.clr_tgl[SF_POL] = ~st_q.clr_tgl[SF_POL];
            if (reg_wdata[IB_TB] && (st_q.clr_tgl[SF_TB] == ack_s[SF_TB]))
                st_d.clr_tgl[SF_TB] = ~st_q.clr_tgl[SF_TB];
        end
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_MODE: reg_rdata[MODE_W-1:0] = st_q.mode;
            SEL_STAT: begin
                reg_rdata[SB_POL_A] = pol_lvl_s[0];
                reg_rdata[SB_POL_B] = pol_lvl_s[1];
            end
            SEL_INT: begin
                reg_rdata[IB_TONE] = tone_flag;
                reg_rdata[IB_FSK]  = fsk_flag;
                reg_rdata[IB_POL]  = flag_s[SF_POL];
                reg_rdata[IB_TB]   = flag_s[SF_TB];
            end
            default: reg_rdata = '0;
        endcase
    end

    assign irq_n = ~(tone_flag | fsk_flag | (|slow_flag));

    AST_CLR_ONE_OUTSTANDING: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (st_q.clr_tgl != ack_s) |=> $stable(st_q.clr_tgl) || (st_q.clr_tgl == $past(ack_s) ^ $past(st_q.clr_tgl) ^ $past(st_q.clr_tgl))); // R10
    AST_MODE_HOLD: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$past(wr_mode) |-> $stable(st_q.mode)); // R1
endmodule

// File: tb/tel_irq_ctrl_test.sv
module tel_irq_ctrl_test;
    localparam int TPS  = 16;
    localparam int SPM  = 4;
    localparam int INIT = 100;

    logic       clk = 1'b0;
    logic       clk_slow = 1'b0;
    logic       fast_run = 1'b1;
    logic       clk_fast;
    logic       rst_n = 1'b0;
    logic       pol_a = 1'b0, pol_b = 1'b0;
    logic       tone_det = 1'b0, tone_lvl_ok = 1'b1, fsk_byte = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int total = 0;
    int bad = 0;
    int slow_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;
    initial begin
        #7;
        forever #150 clk_slow = ~clk_slow;
    end
    assign clk_fast = clk & fast_run;
    always @(posedge clk_slow) slow_cnt <= slow_cnt + 1;

    tel_irq_ctrl #(.TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM), .INIT_CYCLES(INIT)) uut (
        .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
        .pol_a(pol_a), .pol_b(pol_b), .tone_det(tone_det),
        .tone_lvl_ok(tone_lvl_ok), .fsk_byte(fsk_byte),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_slow(input int n);
        repeat (n) @(posedge clk_slow);
        @(negedge clk);
    endtask

    task automatic wait_irq(input logic lvl, output int at);
        at = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (irq_n == lvl) begin
                at = slow_cnt;
                break;
            end
        end
    endtask

    function automatic int exp_flag(input bit en, input bit qual, input bit pulse);
        return int'(en && qual && pulse);
    endfunction

    initial begin
        #1_500_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int t1, t2, t3, tw;
        bit exp_pol;
        void'($urandom(32'd1234));

        #700;
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 mode", v, 0);
        rd(2'd2, v); chk("R1 int", v, 0);
        chk("R1 irq_n", irq_n, 1);

        // R3 status levels
        pol_a = 1'b1; wait_slow(4); rd(2'd1, v); chk("R3 status a", v, 8'h80);
        pol_b = 1'b1; wait_slow(4); rd(2'd1, v); chk("R3 status ab", v, 8'hC0);
        pol_a = 1'b0; wait_slow(4); rd(2'd1, v); chk("R3 status b", v, 8'h40);
        rd(2'd2, v); chk("R2 no flag when disabled", v[6], 0);

        // R2 random polarity stimulus
        for (int it = 0; it < 20; it++) begin
            bit en;
            int sel;
            en = 1'($urandom % 2);
            wr(2'd0, en ? 8'h10 : 8'h00);
            wait_slow(5);
            wr(2'd2, 8'hC0);
            wait_slow(6);
            sel = $urandom % 4;
            if (sel == 1) pol_a = ~pol_a;
            if (sel == 2) pol_b = ~pol_b;
            if (sel == 3) begin pol_a = ~pol_a; pol_b = ~pol_b; end
            exp_pol = bit'(exp_flag(en, sel != 0, 1'b1));
            wait_slow(5);
            rd(2'd2, v); chk("R2 pol flag", v[6], exp_pol);
            rd(2'd1, v); chk("R3 status", v, {pol_a, pol_b, 6'b0});
            chk("R10 irq vs flag", irq_n, !exp_pol);
        end
        wr(2'd0, 8'h00); wait_slow(5); wr(2'd2, 8'hFF); wait_slow(6);
        chk("R10 irq released", irq_n, 1);

        // R4 seconds timebase
        wr(2'd0, 8'h01);
        wait_irq(1'b0, t1);
        wr(2'd2, 8'h80);
        wait_irq(1'b1, tw);
        wait_irq(1'b0, t2);
        chk("R4 second interval", t2 - t1, TPS);
        wr(2'd2, 8'h80);
        wait_irq(1'b1, tw);
        wait_irq(1'b0, t3);
        chk("R4 second interval 2", t3 - t2, TPS);

        // R5 switch to minute right after a tick: restart
        wr(2'd2, 8'h80);
        tw = slow_cnt;
        wr(2'd0, 8'h03);
        wait_irq(1'b1, t1);
        wait_irq(1'b0, t1);
        chk("R5 restart lower", int'((t1 - tw) >= TPS * SPM), 1);
        chk("R5 restart upper", int'((t1 - tw) <= TPS * SPM + 5), 1);
        wr(2'd2, 8'h80);
        wait_irq(1'b1, t2);
        wait_irq(1'b0, t2);
        chk("R5 minute interval", t2 - t1, TPS * SPM);
        wr(2'd0, 8'h00); wait_slow(5); wr(2'd2, 8'hFF); wait_slow(6);

        // R6 power-down: polarity
        wr(2'd0, 8'h10); wait_slow(5); wr(2'd2, 8'hFF); wait_slow(6);
        chk("R6 idle before", irq_n, 1);
        @(negedge clk) fast_run = 1'b0;
        pol_a = ~pol_a;
        wait_slow(4);
        chk("R6 pol irq clock off", irq_n, 0);
        @(negedge clk) fast_run = 1'b1;
        wr(2'd0, 8'h00); wait_slow(5); wr(2'd2, 8'hFF); wait_slow(6);
        // R6 power-down: timebase
        wr(2'd0, 8'h01); wait_slow(5);
        wait_irq(1'b0, tw);
        wr(2'd2, 8'h80); wait_slow(5);
        chk("R6 tb cleared", irq_n, 1);
        @(negedge clk) fast_run = 1'b0;
        wait_slow(TPS + 2);
        chk("R6 tb irq clock off", irq_n, 0);
        @(negedge clk) fast_run = 1'b1;
        wr(2'd0, 8'h00); wait_slow(5); wr(2'd2, 8'hFF); wait_slow(6);

        // R7 exact warm-up boundary
        tone_lvl_ok = 1'b1;
        wr(2'd0, 8'h04);
        reg_addr = 2'd2;
        repeat (INIT - 1) @(posedge clk);
        @(negedge clk) tone_det = 1'b1;
        @(negedge clk);
        #1 chk("R7 pulse inside window", reg_rdata[1], 0);
        @(negedge clk) tone_det = 1'b0;
        #1 chk("R7 pulse after window", reg_rdata[1], 1);
        chk("R10 irq on tone", irq_n, 0);

        // R10 selective clear
        wr(2'd0, 8'h0C);
        @(negedge clk) fsk_byte = 1'b1;
        @(negedge clk) fsk_byte = 1'b0;
        wr(2'd2, 8'h00);
        rd(2'd2, v); chk("R10 zero write keeps", v, 8'h22);
        wr(2'd2, 8'h02);
        rd(2'd2, v); chk("R10 clear tone only", v, 8'h20);
        chk("R10 irq still low", irq_n, 0);
        wr(2'd2, 8'h20);
        rd(2'd2, v); chk("R10 clear fsk", v, 8'h00);
        chk("R10 irq high", irq_n, 1);

        // R7 R8 R9 random tone and fsk stimulus
        for (int it = 0; it < 24; it++) begin
            bit te, fe, lv, tp, fp;
            te = 1'($urandom % 2); fe = 1'($urandom % 2);
            lv = 1'($urandom % 2); tp = 1'($urandom % 2); fp = 1'($urandom % 2);
            wr(2'd0, 8'h00);
            wr(2'd0, {4'b0, fe, te, 2'b0});
            repeat (INIT + 5) @(negedge clk);
            wr(2'd2, 8'h22);
            tone_lvl_ok = lv;
            @(negedge clk) begin tone_det = tp; fsk_byte = fp; end
            @(negedge clk) begin tone_det = 1'b0; fsk_byte = 1'b0; end
            rd(2'd2, v);
            chk("R8 tone flag", v[1], exp_flag(te, lv, tp));
            chk("R9 fsk flag", v[5], exp_flag(fe, 1'b1, fp));
        end
        tone_lvl_ok = 1'b1;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule